// File: doc/BRIEF.md
# Serial Real-Time Clock with Parameter RAM

This block sits behind three host-driven lines: an active-low select (`ser_en_n`), a serial clock (`ser_clk`) and a data line split into an input (`ser_din`) and a driven output with its own enable (`ser_dout`, `ser_dout_oe`). While select is low, the host shifts in a command byte, most significant bit first, followed by zero to two further bytes. Read commands shift a reply byte back. All three lines are sampled in the `clk` domain and must change slowly compared with `clk`, at least two `clk` cycles per serial clock phase.

The block keeps a 32-bit seconds counter that advances on each `sec_tick` pulse and takes the value of `sec_preset` while reset is held. It also holds a protect flag and a 256-byte RAM. The low 20 bytes of that RAM can be reached with one-byte commands. All 256 bytes can be reached with a sector-plus-offset sequence. Reset clears the RAM and the protect flag.

The transfer FSM has five states. `ST_CMD` collects the command byte. `ST_ARG` collects the data or offset byte. `ST_XDATA` collects the data byte of an extended write. `ST_REPLY` shifts a reply byte out. `ST_DROP` ignores the line until select rises. The transitions are:
- *abort*: any state goes to `ST_CMD` while select is high.
- *read-short*: `ST_CMD` goes to `ST_REPLY`.
- *read-ext* and *write*: `ST_CMD` goes to `ST_ARG`.
- *reject*: `ST_CMD` goes to `ST_DROP` on an undecodable or protected command.
- *ext-read*: `ST_ARG` goes to `ST_REPLY`.
- *ext-write*: `ST_ARG` goes to `ST_XDATA`.
- *done*: `ST_ARG`, `ST_XDATA` or `ST_REPLY` goes back to `ST_CMD`.

Top module: `rtc_serial_pram`

## Requirements
- R1: While `ser_en_n` is high, the bit count, command state and reply are cleared, the data output is not driven, and a partly shifted byte has no effect.
- R2: Host bits are taken on rising edges of `ser_clk`, MSB first. Reply bits are presented on falling edges, MSB first. The first reply bit appears on the falling edge that ends the last request byte. `ser_dout_oe` is high only while reply bits are shown, and it drops on the falling edge after bit 0.
- R3: Command bit 7 = 1 means read and 0 means write. A command with bits 6:4 = 000 and bits 1:0 = 01 reads or writes seconds byte s = bits 3:2, where byte 0 is bits 7:0 of the counter.
- R4: A seconds write replaces the addressed byte with the data byte. Each `sec_tick` pulse adds one to the counter. When a tick and a seconds write fall in the same cycle, the write wins.
- R5: While `rst_n` is low, the counter loads `sec_preset`, every RAM byte becomes 0 and the protect flag clears.
- R6: A command with bit 6 = 1 and bits 1:0 = 01 (but not matching R3 or R8) addresses RAM byte bits 5:2, in the range 0x00..0x0F.
- R7: A command with bits 6:4 = 010 and bits 1:0 = 01 addresses RAM byte 0x10 + bits 3:2.
- R8: A command with bits 6:3 = 0111 is extended, with sector = bits 2:0. The next byte gives the offset in bits 6:2, and the RAM index is sector*32 + offset. A read replies after that byte. A write takes a third byte as data. Short and extended commands share one RAM.
- R9: Write-only command 0x35 loads the protect flag from data bit 7. While the flag is set, every write except 0x35 is discarded and reads still work. Write-only command 0x31 accepts a byte with no effect.
- R10: An undecodable command byte is rejected: nothing is written, `ser_dout_oe` stays low, and all bytes are ignored until `ser_en_n` rises. This includes 0xB1, 0xB5, any byte with bits 1:0 other than 01 (except extended commands), and bits 6:4 = 001.
- R11: After a command completes, the next byte under the same select low is a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_preset | input | 32 | Counter value loaded during reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| ser_en_n | input | 1 | Active-low transfer select |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial reply data |
| ser_dout_oe | output | 1 | High while the block drives the data line |

## Verification
A wrong bit count or FSM state shows up at the ports within one byte. The next reply comes back shifted or not at all, or `ser_dout_oe` rises where no reply is due. A wrong RAM index, seconds byte select or protect flag stays hidden until a later read of the affected location. For that reason, every write scenario is followed by a read-back, and a decoy location is also read. Abort and reject cases are judged by reading the target byte in a fresh transfer afterwards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [2:0] {
        ST_CMD,
        ST_ARG,
        ST_XDATA,
        ST_REPLY,
        ST_DROP
    } xfer_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_SEC,
        K_TEST,
        K_PROT,
        K_RAM,
        K_XSECT
    } cmd_kind_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
    import rtc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [7:0]       code,
    output logic             is_rd,
    output cmd_kind_t        kind,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        is_rd = code[7];
        kind  = K_NONE;
        idx   = '0;
        if (code[6:3] == 4'b0111) begin
            kind = K_XSECT;
            idx  = IDX_W'(code[2:0]);
        end else if (code[1:0] == 2'b01) begin
            if (code[6:4] == 3'b000) begin
                kind = K_SEC;
                idx  = IDX_W'(code[3:2]);
            end else if (code[6:2] == 5'b01100) begin
                kind = code[7] ? K_NONE : K_TEST;
            end else if (code[6:2] == 5'b01101) begin
                kind = code[7] ? K_NONE : K_PROT;
            end else if (code[6:4] == 3'b010) begin
                kind = K_RAM;
                idx  = IDX_W'({3'b100, code[3:2]});
            end else if (code[6]) begin
                kind = K_RAM;
                idx  = IDX_W'(code[5:2]);
            end
        end
    end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int CNT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             preset,
    input  logic                         tick,
    input  logic                         wr_en,
    input  logic [$clog2(CNT_W/8)-1:0]   wr_sel,
    input  logic [7:0]                   wr_byte,
    output logic [CNT_W-1:0]             count
);
    localparam int NBYTES = CNT_W / 8;
    localparam int SEL_W  = $clog2(NBYTES);

    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt = count;
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_sel == SEL_W'(b)) nxt[b*8 +: 8] = wr_byte;
            end
        end else if (tick) begin
            nxt = count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= preset;
        else        count <= nxt;
    end

    assert_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_serial_pram.sv
module rtc_serial_pram
    import rtc_pkg::*;
#(
    parameter int RAM_DEPTH = 256,
    parameter int SEC_W     = 32,
    parameter int SECT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] sec_preset,
    input  logic             sec_tick,
    input  logic             ser_en_n,
    input  logic             ser_clk,
    input  logic             ser_din,
    output logic             ser_dout,
    output logic             ser_dout_oe
);
    localparam int AW      = $clog2(RAM_DEPTH);
    localparam int XADDR_W = AW - SECT_W;
    localparam int SEL_W   = $clog2(SEC_W / 8);

    xfer_state_t      state, nstate;
    cmd_kind_t        kind_q, dk;
    logic             rd_q, drd;
    logic [AW-1:0]    idx_q, didx;
    logic [XADDR_W-1:0] xaddr_q;
    logic [2:0]       bitcnt;
    logic [7:0]       sh, reply, byte_val, rdata;
    logic [3:0]       rcnt;
    logic             sclk_q, rise, fall, shifting, byte_done;
    logic             prot_q, dout_q;
    logic             arg_done, ram_we, sec_we;
    logic [AW-1:0]    raddr, waddr;
    logic [SEC_W-1:0] sec_count, sec_shift;

    assign rise      = ser_clk & ~sclk_q;
    assign fall      = ~ser_clk & sclk_q;
    assign shifting  = (state == ST_CMD) || (state == ST_ARG) || (state == ST_XDATA);
    assign byte_done = !ser_en_n && rise && shifting && (bitcnt == 3'd7);
    assign byte_val  = {sh[6:0], ser_din};
    assign arg_done  = byte_done && (state == ST_ARG);

    rtc_cmd_decode #(.IDX_W(AW)) u_dec (
        .code  (byte_val),
        .is_rd (drd),
        .kind  (dk),
        .idx   (didx)
    );

    // ---------------- state register ----------------
    always_comb begin
        nstate = state;
        if (ser_en_n) begin
            nstate = ST_CMD;
        end else begin
            unique case (state)
                ST_CMD: if (byte_done) begin
                    if (dk == K_NONE)              nstate = ST_DROP;
                    else if (drd)                  nstate = (dk == K_XSECT) ? ST_ARG : ST_REPLY;
                    else if (prot_q && dk != K_PROT) nstate = ST_DROP;
                    else                           nstate = ST_ARG;
                end
                ST_ARG: if (byte_done) begin
                    if (kind_q == K_XSECT) nstate = rd_q ? ST_REPLY : ST_XDATA;
                    else                   nstate = ST_CMD;
                end
                ST_XDATA: if (byte_done) nstate = ST_CMD;
                ST_REPLY: if (fall && rcnt == 4'd8) nstate = ST_CMD;
                ST_DROP:  nstate = ST_DROP;
                default:  nstate = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= nstate;
    end

    // ---------------- storage access ----------------
    assign ram_we = (arg_done && kind_q == K_RAM && !rd_q) ||
                    (byte_done && state == ST_XDATA);
    assign waddr  = (state == ST_XDATA) ? {idx_q[SECT_W-1:0], xaddr_q} : idx_q;
    assign raddr  = (state == ST_ARG) ? {idx_q[SECT_W-1:0], byte_val[6:2]} : didx;
    assign sec_we = arg_done && kind_q == K_SEC && !rd_q;
    assign sec_shift = sec_count >> {didx[SEL_W-1:0], 3'b000};

    rtc_ram #(.DEPTH(RAM_DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (waddr),
        .wdata (byte_val),
        .raddr (raddr),
        .rdata (rdata)
    );

    rtc_seconds #(.CNT_W(SEC_W)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (sec_preset),
        .tick    (sec_tick),
        .wr_en   (sec_we),
        .wr_sel  (idx_q[SEL_W-1:0]),
        .wr_byte (byte_val),
        .count   (sec_count)
    );

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bitcnt  <= '0;
            sh      <= '0;
            reply   <= '0;
            rcnt    <= '0;
            dout_q  <= 1'b0;
            kind_q  <= K_NONE;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            xaddr_q <= '0;
            prot_q  <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
            if (arg_done && kind_q == K_PROT) prot_q <= byte_val[7];
            if (ser_en_n) begin
                bitcnt <= '0;
                sh     <= '0;
                rcnt   <= '0;
                dout_q <= 1'b0;
                kind_q <= K_NONE;
                rd_q   <= 1'b0;
            end else begin
                if (rise && shifting) begin
                    sh     <= byte_val;
                    bitcnt <= bitcnt + 3'd1;
                end
                if (byte_done && state == ST_CMD) begin
                    kind_q <= dk;
                    rd_q   <= drd;
                    idx_q  <= didx;
                    rcnt   <= '0;
                    if (drd && dk == K_SEC) reply <= sec_shift[7:0];
                    if (drd && dk == K_RAM) reply <= rdata;
                end
                if (arg_done && kind_q == K_XSECT) begin
                    xaddr_q <= byte_val[6:2];
                    rcnt    <= '0;
                    if (rd_q) reply <= rdata;
                end
                if (state == ST_REPLY && fall && rcnt < 4'd8) begin
                    dout_q <= reply[7];
                    reply  <= {reply[6:0], 1'b0};
                    rcnt   <= rcnt + 4'd1;
                end
            end
        end
    end

    assign ser_dout    = dout_q;
    assign ser_dout_oe = (state == ST_REPLY) && (rcnt != 4'd0);

    // ---------------- assertions ----------------
    assert_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en_n |=> (state == ST_CMD && bitcnt == 3'd0 && !ser_dout_oe));

    assert_oe_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_dout_oe |-> !ser_en_n);

    assert_bit_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en_n && rise && shifting) |=> (bitcnt == $past(bitcnt) + 3'd1));

    assert_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || sec_we) |-> !prot_q);

    assert_drop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP && !ser_en_n) |=> (state == ST_DROP && !ser_dout_oe));
endmodule

// File: tb/sim_rtc_serial_pram.sv
`timescale 1ns/1ps
module sim_rtc_serial_pram;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sec_preset;
    logic        sec_tick;
    logic        ser_en_n, ser_clk, ser_din;
    logic        ser_dout, ser_dout_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rtc_serial_pram u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_preset  (sec_preset),
        .sec_tick    (sec_tick),
        .ser_en_n    (ser_en_n),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .ser_dout    (ser_dout),
        .ser_dout_oe (ser_dout_oe)
    );

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sel_on;  ser_en_n = 1'b0; wclk(4); endtask
    task automatic sel_off; ser_en_n = 1'b1; ser_clk = 1'b0; wclk(4); endtask

    task automatic put_bit(input logic b);
        ser_din = b; wclk(4);
        ser_clk = 1'b1; wclk(4);
        ser_clk = 1'b0; wclk(4);
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    // samples after each falling edge; counts samples with output enabled
    task automatic get_byte(output logic [7:0] v, output int oe_cnt);
        oe_cnt = 0;
        v = '0;
        for (int i = 7; i >= 0; i--) begin
            v[i] = ser_dout;
            if (ser_dout_oe) oe_cnt++;
            ser_clk = 1'b1; wclk(4);
            ser_clk = 1'b0; wclk(4);
        end
    endtask

    task automatic rd_short(input logic [7:0] cmd, output logic [7:0] v);
        int oe;
        sel_on; put_byte(cmd); get_byte(v, oe); sel_off;
        check("R2 oe during reply", oe, 8);
    endtask

    task automatic wr_short(input logic [7:0] cmd, input logic [7:0] d);
        sel_on; put_byte(cmd); put_byte(d); sel_off;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R2 oe idle after reset", ser_dout_oe, 0);
        rd_short(8'h81, v); check("R5 R3 sec byte0", v, 8'h78);
        rd_short(8'h85, v); check("R5 R3 sec byte1", v, 8'h56);
        rd_short(8'h89, v); check("R5 R3 sec byte2", v, 8'h34);
        rd_short(8'h8D, v); check("R5 R3 sec byte3", v, 8'h12);
        rd_short(8'hC1, v); check("R5 ram zero", v, 8'h00);
    endtask

    task automatic t_ram_low;
        logic [7:0] v;
        wr_short(8'h55, 8'hA5);
        rd_short(8'hD5, v); check("R6 ram 0x05", v, 8'hA5);
        rd_short(8'hD1, v); check("R6 neighbour 0x04", v, 8'h00);
    endtask

    task automatic t_ram_high;
        logic [7:0] v;
        wr_short(8'h29, 8'h3C);
        rd_short(8'hA9, v); check("R7 ram 0x12", v, 8'h3C);
    endtask

    task automatic t_extended;
        logic [7:0] v;
        int oe;
        sel_on; put_byte(8'h3A); put_byte(8'h1C); put_byte(8'h99); sel_off;
        sel_on; put_byte(8'hBA); put_byte(8'h1C); get_byte(v, oe); sel_off;
        check("R8 ext read s2 a7", v, 8'h99);
        check("R8 ext reply oe", oe, 8);
        sel_on; put_byte(8'hB8); put_byte(8'h14); get_byte(v, oe); sel_off;
        check("R8 ext s0 a5 shares short ram", v, 8'hA5);
    endtask

    task automatic t_seconds;
        logic [7:0] v;
        wr_short(8'h09, 8'hEE);
        rd_short(8'h89, v); check("R4 sec byte2 write", v, 8'hEE);
        rd_short(8'h85, v); check("R4 sec byte1 kept", v, 8'h56);
        for (int i = 0; i < 3; i++) begin
            sec_tick = 1'b1; wclk(1); sec_tick = 1'b0; wclk(1);
        end
        rd_short(8'h81, v); check("R4 tick x3", v, 8'h7B);
    endtask

    task automatic t_protect;
        logic [7:0] v;
        wr_short(8'h35, 8'h80);
        wr_short(8'h55, 8'h11);
        rd_short(8'hD5, v); check("R9 ram write ignored", v, 8'hA5);
        wr_short(8'h01, 8'h00);
        rd_short(8'h81, v); check("R9 sec write ignored", v, 8'h7B);
        wr_short(8'h35, 8'h00);
        wr_short(8'h55, 8'h11);
        rd_short(8'hD5, v); check("R9 write after unprotect", v, 8'h11);
        wr_short(8'h31, 8'hFF);
        rd_short(8'hD5, v); check("R9 test reg no effect ram", v, 8'h11);
        rd_short(8'h81, v); check("R9 test reg no effect sec", v, 8'h7B);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        sel_on; put_byte(8'h55); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        ser_en_n = 1'b1; wclk(2);
        check("R1 oe low on abort", ser_dout_oe, 0);
        wclk(2);
        rd_short(8'hD5, v); check("R1 partial write dropped", v, 8'h11);
        sel_on; put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); sel_off;
        rd_short(8'hD5, v); check("R1 counters cleared", v, 8'h11);
    endtask

    task automatic t_invalid;
        logic [7:0] v;
        int oe;
        sel_on; put_byte(8'h02); put_byte(8'h55); put_byte(8'h00); sel_off;
        rd_short(8'hD5, v); check("R10 bad cmd drops following", v, 8'h11);
        sel_on; put_byte(8'hB1); get_byte(v, oe); sel_off;
        check("R10 read of test reg no reply", oe, 0);
        sel_on; put_byte(8'h11); put_byte(8'h55); put_byte(8'h00); sel_off;
        rd_short(8'hD5, v); check("R10 bits6:4=001 rejected", v, 8'h11);
    endtask

    task automatic t_chain;
        logic [7:0] v;
        int oe;
        sel_on; put_byte(8'h55); put_byte(8'h22); put_byte(8'hD5); get_byte(v, oe);
        put_byte(8'hA9); get_byte(v, oe); sel_off;
        check("R11 second read in one select", v, 8'h3C);
        rd_short(8'hD5, v); check("R11 chained write", v, 8'h22);
    endtask

    initial begin
        rst_n = 1'b0; sec_preset = 32'h1234_5678; sec_tick = 1'b0;
        ser_en_n = 1'b1; ser_clk = 1'b0; ser_din = 1'b0;
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        t_reset;
        t_ram_low;
        t_ram_high;
        t_extended;
        t_seconds;
        t_protect;
        t_abort;
        t_invalid;
        t_chain;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule